// File: doc/BRIEF.md
# Tile-Triggered Pattern Bank Switch

This block sits on the video side of a cartridge memory mapper. It watches the 14-bit address of every video-memory fetch and maps the 8 KB pattern space onto a 128 KB pattern ROM in two 4 KB halves: a low table (`0x0000-0x0FFF`) and a high table (`0x1000-0x1FFF`). Each half has two candidate 5-bit bank numbers, written elsewhere by the CPU. A one-bit marker per half picks which of the two candidates is used.

The markers switch without CPU help. When the fetcher reads one of two particular tile rows near the end of a table, the marker for that table flips to the matching candidate. A graphics program can place these trigger tiles in the screen so that everything to their right draws from a different bank. The ROM address is the selected bank above the low 12 address bits, formed combinationally. The marker is registered, so the fetch that hits a trigger row still comes from the old bank.

Top module: `tile_bank_switch`

## Requirements
- R1: After reset both markers are in the alternate state (encoding 1). A low-table fetch uses `bank_lo_alt` and a high-table fetch uses `bank_hi_alt`.
- R2: `rom_addr` equals {selected bank, `fetch_addr[11:0]`}. Bit 12 of `fetch_addr` picks the table: 0 is low, 1 is high. The table's marker picks that table's primary register (marker 0) or alternate register (marker 1).
- R3: A read strobe at a low-table address `0x0FD8` to `0x0FDF` sets the low marker to primary.
- R4: A read strobe at a low-table address `0x0FE8` to `0x0FEF` sets the low marker to alternate.
- R5: A read strobe at a high-table address sets the high marker the same way: `0x1FD8` to `0x1FDF` selects primary and `0x1FE8` to `0x1FEF` selects alternate.
- R6: A marker changes at the clock edge that ends the triggering fetch. The triggering fetch itself still sees the old bank, and the next cycle sees the new one.
- R7: A trigger in one table leaves the other table's marker unchanged.
- R8: A marker never changes when `fetch_rd` is low, when `fetch_addr` is `0x2000` or above, or when the address lies just outside the trigger rows (for example `0x0FD7`, `0x0FE0`, `0x0FF0`).
- R9: A change of a bank register input shows on `rom_addr` in the same cycle, with no register delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fetch_addr | input | 14 | Video-memory fetch address |
| fetch_rd | input | 1 | Read strobe for the current fetch |
| bank_lo_pri | input | 5 | Low-table bank used when the low marker is primary |
| bank_lo_alt | input | 5 | Low-table bank used when the low marker is alternate |
| bank_hi_pri | input | 5 | High-table bank used when the high marker is primary |
| bank_hi_alt | input | 5 | High-table bank used when the high marker is alternate |
| rom_addr | output | 17 | Pattern ROM address |

## Verification
Some properties are checked on every clock cycle:
- At most one trigger fires per cycle.
- No trigger fires without a read, or for an address in the nametable range.
- Each marker moves exactly as its two triggers demand in the following cycle, and holds otherwise.
- The upper ROM address bits always carry one of the two bank registers for the current table.

Other behaviour only the bench scenarios can show. These are the exact boundaries of the trigger rows, the one-cycle lag between a trigger and the bank switch, the independence of the two tables, and the same-cycle effect of bank register changes. A behavioural model predicts `rom_addr` for each of these, and the bench compares it every cycle.

// File: rtl/tbs_pkg.sv
package tbs_pkg;
    localparam int ADDR_W  = 14;
    localparam int PAGE_W  = 12;
    localparam int ROW_LSB = 3;
    localparam int ROW_W   = PAGE_W - ROW_LSB;

    // Tile-row indices (address bits 11:3) that act as triggers
    localparam logic [ROW_W-1:0] ROW_PRI = 9'h1FB;  // x_FD8..x_FDF
    localparam logic [ROW_W-1:0] ROW_ALT = 9'h1FD;  // x_FE8..x_FEF

    typedef enum logic {
        MARK_PRI = 1'b0,
        MARK_ALT = 1'b1
    } mark_e;

    typedef struct packed {
        mark_e mark;
    } latch_st_t;
endpackage

// File: rtl/tbs_row_detect.sv
module tbs_row_detect
    import tbs_pkg::*;
#(
    parameter logic TABLE = 1'b0
) (
    input  logic                     rd,
    input  logic [ADDR_W-1:ROW_LSB]  row_addr,
    output logic                     hit_pri,
    output logic                     hit_alt
);
    logic in_table;

    always_comb begin
        in_table = rd && !row_addr[ADDR_W-1] && (row_addr[PAGE_W] == TABLE);
        hit_pri  = in_table && (row_addr[PAGE_W-1:ROW_LSB] == ROW_PRI);
        hit_alt  = in_table && (row_addr[PAGE_W-1:ROW_LSB] == ROW_ALT);
    end
endmodule

// File: rtl/tbs_mark_latch.sv
module tbs_mark_latch
    import tbs_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  hit_pri,
    input  logic  hit_alt,
    output mark_e mark
);
    latch_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (hit_pri) begin
            st_d.mark = MARK_PRI;
        end else if (hit_alt) begin
            st_d.mark = MARK_ALT;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mark <= MARK_ALT;
        end else begin
            st_q <= st_d;
        end
    end

    assign mark = st_q.mark;

    // R3 / R5: a primary-row hit leaves the marker primary next cycle
    a_r3_set_pri: assert property (@(posedge clk) disable iff (!rst_n)
        hit_pri |=> (mark == MARK_PRI));

    // R4 / R5: an alternate-row hit leaves the marker alternate next cycle
    a_r4_set_alt: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_alt && !hit_pri) |=> (mark == MARK_ALT));

    // R8: no hit, no change
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit_pri && !hit_alt) |=> $stable(mark));
endmodule

// File: rtl/tbs_bank_mux.sv
module tbs_bank_mux
    import tbs_pkg::*;
#(
    parameter int BANK_W = 5
) (
    input  logic              table_hi,
    input  mark_e             mark_lo,
    input  mark_e             mark_hi,
    input  logic [BANK_W-1:0] lo_pri,
    input  logic [BANK_W-1:0] lo_alt,
    input  logic [BANK_W-1:0] hi_pri,
    input  logic [BANK_W-1:0] hi_alt,
    output logic [BANK_W-1:0] bank
);
    always_comb begin
        if (table_hi) begin
            bank = (mark_hi == MARK_PRI) ? hi_pri : hi_alt;
        end else begin
            bank = (mark_lo == MARK_PRI) ? lo_pri : lo_alt;
        end
    end
endmodule

// File: rtl/tile_bank_switch.sv
module tile_bank_switch
    import tbs_pkg::*;
#(
    parameter int BANK_W = 5,
    localparam int ROM_W = BANK_W + PAGE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic              fetch_rd,
    input  logic [BANK_W-1:0] bank_lo_pri,
    input  logic [BANK_W-1:0] bank_lo_alt,
    input  logic [BANK_W-1:0] bank_hi_pri,
    input  logic [BANK_W-1:0] bank_hi_alt,
    output logic [ROM_W-1:0]  rom_addr
);
    localparam int N_TABLES = 2;

    logic [N_TABLES-1:0] hit_pri;
    logic [N_TABLES-1:0] hit_alt;
    mark_e               mark [N_TABLES];
    logic [BANK_W-1:0]   bank;

    for (genvar t = 0; t < N_TABLES; t++) begin : g_table
        tbs_row_detect #(.TABLE(t[0])) det_i (
            .rd       (fetch_rd),
            .row_addr (fetch_addr[ADDR_W-1:ROW_LSB]),
            .hit_pri  (hit_pri[t]),
            .hit_alt  (hit_alt[t])
        );

        tbs_mark_latch lat_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .hit_pri (hit_pri[t]),
            .hit_alt (hit_alt[t]),
            .mark    (mark[t])
        );
    end

    tbs_bank_mux #(.BANK_W(BANK_W)) mux_i (
        .table_hi (fetch_addr[PAGE_W]),
        .mark_lo  (mark[0]),
        .mark_hi  (mark[1]),
        .lo_pri   (bank_lo_pri),
        .lo_alt   (bank_lo_alt),
        .hi_pri   (bank_hi_pri),
        .hi_alt   (bank_hi_alt),
        .bank     (bank)
    );

    assign rom_addr = {bank, fetch_addr[PAGE_W-1:0]};

    // R7: at most one trigger across both tables
    a_r7_one_trigger: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({hit_pri, hit_alt}));

    // R8: nametable-range fetches and non-reads never trigger
    a_r8_quiet_range: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_addr[ADDR_W-1] || !fetch_rd) |-> ({hit_pri, hit_alt} == '0));

    // R2: upper address bits carry one of the current table's banks
    a_r2_bank_source: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_addr[PAGE_W]
            ? (rom_addr[ROM_W-1:PAGE_W] == bank_hi_pri || rom_addr[ROM_W-1:PAGE_W] == bank_hi_alt)
            : (rom_addr[ROM_W-1:PAGE_W] == bank_lo_pri || rom_addr[ROM_W-1:PAGE_W] == bank_lo_alt));
endmodule

// File: tb/tile_bank_switch_tb.sv
module tile_bank_switch_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [13:0] fetch_addr = '0;
    logic        fetch_rd = 1'b0;
    logic [4:0]  bank_lo_pri = 5'd3;
    logic [4:0]  bank_lo_alt = 5'd12;
    logic [4:0]  bank_hi_pri = 5'd21;
    logic [4:0]  bank_hi_alt = 5'd30;
    logic [16:0] rom_addr;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;
    bit done = 0;

    // behavioural reference: 0 = primary, 1 = alternate
    int ref_lo = 1;
    int ref_hi = 1;

    always #10 clk = ~clk;  // 50 MHz

    tile_bank_switch dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .fetch_addr  (fetch_addr),
        .fetch_rd    (fetch_rd),
        .bank_lo_pri (bank_lo_pri),
        .bank_lo_alt (bank_lo_alt),
        .bank_hi_pri (bank_hi_pri),
        .bank_hi_alt (bank_hi_alt),
        .rom_addr    (rom_addr)
    );

    function automatic logic [16:0] predict(input logic [13:0] a);
        int bank;
        if (a[12]) bank = (ref_hi == 0) ? int'(bank_hi_pri) : int'(bank_hi_alt);
        else       bank = (ref_lo == 0) ? int'(bank_lo_pri) : int'(bank_lo_alt);
        return 17'(bank * 4096 + (int'(a) % 4096));
    endfunction

    task automatic compare(input string tag);
        logic [16:0] exp_v;
        exp_v = predict(fetch_addr);
        n_cmp++;
        if (rom_addr !== exp_v) begin
            n_bad++;
            $display("FAIL %s addr=%h actual=%h expected=%h", tag, fetch_addr, rom_addr, exp_v);
        end
    endtask

    // drive one fetch, compare before the edge, then advance the model
    task automatic fetch(input logic [13:0] a, input logic rd, input string tag);
        int off;
        @(negedge clk);
        fetch_addr = a;
        fetch_rd = rd;
        #2;
        compare(tag);
        if (rd && int'(a) < 'h2000) begin
            off = int'(a) % 4096;
            if (off >= 'hFD8 && off <= 'hFDF) begin
                if (a[12]) ref_hi = 0; else ref_lo = 0;
            end else if (off >= 'hFE8 && off <= 'hFEF) begin
                if (a[12]) ref_hi = 1; else ref_lo = 1;
            end
        end
    endtask

    initial begin
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                n_bad++;
                $display("FAIL watchdog actual=%0d expected<100000", cycles);
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state, both tables on alternate banks
        fetch(14'h0123, 1'b0, "R1 low reset");
        fetch(14'h1456, 1'b0, "R1 high reset");
        // R3 / R6: trigger fetch uses old bank, next fetch new one
        fetch(14'h0FD8, 1'b1, "R6 trigger cycle old bank");
        fetch(14'h0040, 1'b1, "R3 low now primary");
        // R7: high table untouched
        fetch(14'h1040, 1'b1, "R7 high still alternate");
        // R4: upper end of alternate row
        fetch(14'h0FEF, 1'b1, "R4 trigger");
        fetch(14'h0800, 1'b1, "R4 low now alternate");
        fetch(14'h0FDF, 1'b1, "R3 upper end of row");
        fetch(14'h0001, 1'b1, "R3 low primary");
        // R8: neighbours, non-reads and nametable range
        fetch(14'h0FE0, 1'b1, "R8 just past primary row");
        fetch(14'h0FE7, 1'b1, "R8 just before alternate row");
        fetch(14'h0FF0, 1'b1, "R8 just past alternate row");
        fetch(14'h0FE8, 1'b0, "R8 no strobe");
        fetch(14'h2FE8, 1'b1, "R8 nametable alias");
        fetch(14'h3FE8, 1'b1, "R8 nametable high");
        fetch(14'h0FD7, 1'b1, "R8 just before primary row");
        fetch(14'h0222, 1'b1, "R8 low still primary");
        // R5: high table
        fetch(14'h1FDC, 1'b1, "R5 high primary trigger");
        fetch(14'h1AAA, 1'b1, "R5 high now primary");
        fetch(14'h0AAA, 1'b1, "R7 low unchanged");
        fetch(14'h1FE8, 1'b1, "R5 high alternate trigger");
        fetch(14'h1FFF, 1'b1, "R5 high now alternate");
        fetch(14'h0FD8, 1'b1, "R7 cross table trigger");
        fetch(14'h1BCD, 1'b1, "R7 high unaffected by low trigger");
        // R9: bank register changes are immediate
        @(negedge clk);
        bank_lo_pri = 5'd31;
        bank_hi_alt = 5'd0;
        fetch(14'h0ABC, 1'b1, "R9 low bank update");
        fetch(14'h1ABC, 1'b1, "R9 high bank update");
        // R2: sweep of mixed fetches
        for (int i = 0; i < 200; i++) begin
            logic [13:0] a;
            a = 14'($urandom_range(0, 'h3FFF));
            if (i % 5 == 0) a = {1'b0, a[12], 12'hFD8} | 14'(i % 8);
            if (i % 7 == 0) a = {1'b0, a[12], 12'hFE8} | 14'(i % 8);
            if (i % 11 == 0) bank_lo_alt = 5'($urandom);
            fetch(a, 1'($urandom_range(0, 3) != 0), "R2 sweep");
        end
        // R1: reset mid-run restores alternate
        @(negedge clk);
        rst_n = 1'b0;
        ref_lo = 1;
        ref_hi = 1;
        @(negedge clk);
        rst_n = 1'b1;
        fetch(14'h0100, 1'b0, "R1 low after reset");
        fetch(14'h1100, 1'b0, "R1 high after reset");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        done = 1;
        $finish;
    end
endmodule